// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one clock. Each channel has its own prescaler, which divides the input clock by (prescale + 1). It also has a high-time count and a period count, both measured in prescaled ticks. Software configures the channels through a simple 32-bit register port that has a write strobe and a combinational read path. A single master enable sits above all four per-channel enables.

Duty, period and prescale writes go into the programming registers at once. A running channel copies them into its working set only at the end of the current period, so an update never cuts a pulse short. Clearing a channel's enable or the master enable forces that output low and parks its counters. Setting the enable again starts a fresh period.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: After reset, every register reads zero and every output is low.
- R2: Channel n owns the 16-byte window at byte address n*0x10. The control word is at window offset 0x0, the high-time count at 0x4 and the period count at 0x8. The master word is at 0x3C. Each of these registers reads back the last value written.
- R3: Bits outside the defined fields read as zero. The control word keeps bit 0 and bits 15:2 only. The master word keeps bit 0. The count words keep bits 15:0. Addresses that map to no register read zero.
- R4: In the control word, bit 0 is the channel enable and bits 15:2 hold a 14-bit prescale value P.
- R5: A running channel with period count N >= 1 and high-time count D < N has an output period of (P+1)*N clock cycles. The output is high for the first (P+1)*D of those cycles and low for the rest.
- R6: While master bit 0 is clear, all outputs are low, whatever the channel enables say.
- R7: A channel whose enable is clear drives its output low from the cycle after the write. Once both enables are set, the output first rises two cycles after the enabling write, and a full period starts from that point.
- R8: Duty, period and prescale values written while a channel runs take effect only at the next period boundary.
- R9: When D >= N with N >= 1, the output stays high for the whole time the channel runs.
- R10: When N = 0, the output stays low.
- R11: Channels run independently; programming one does not change the timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Combinational read data for rd_addr |
| pwm_o | output | 4 | One waveform per channel |

## Verification
The bench builds the block with its default parameters: four channels, a 14-bit prescale and 16-bit counts. The four channels get prescale values 0, 2, 4 and 1 with short periods. This keeps several full periods, a mid-period update, a zero period and a high-time larger than the period all within a few hundred cycles. The default width also allows the all-ones write to the control word, which shows that the reserved bit 1 is masked.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int WIN_W    = 4;
  localparam int EN_BIT   = 0;
  localparam int PRE_LSB  = 2;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_HIGH = 4'h4;
  localparam logic [3:0] OFF_SPAN = 4'h8;
  localparam logic [7:0] MASTER_ADDR = 8'h3C;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRE_W  = 14,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          master_en,
  output logic [NUM_CH-1:0]             ch_en,
  output logic [NUM_CH-1:0][PRE_W-1:0]  ch_pre,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ch_high,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ch_span
);
  localparam int SEL_W = ADDR_W - WIN_W;
  localparam logic [ADDR_W-1:0] MASTER_A = ADDR_W'(MASTER_ADDR);

  logic                         master_q, master_n;
  logic [NUM_CH-1:0]            en_q, en_n;
  logic [NUM_CH-1:0][PRE_W-1:0] pre_q, pre_n;
  logic [NUM_CH-1:0][CNT_W-1:0] high_q, high_n;
  logic [NUM_CH-1:0][CNT_W-1:0] span_q, span_n;

  always_comb begin
    master_n = master_q;
    en_n     = en_q;
    pre_n    = pre_q;
    high_n   = high_q;
    span_n   = span_q;
    if (wr_addr == MASTER_A) master_n = wr_data[EN_BIT];
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr_addr[ADDR_W-1:WIN_W] == c[SEL_W-1:0]) begin
        case (wr_addr[WIN_W-1:0])
          OFF_CTRL: begin
            en_n[c]  = wr_data[EN_BIT];
            pre_n[c] = wr_data[PRE_LSB +: PRE_W];
          end
          OFF_HIGH: high_n[c] = wr_data[CNT_W-1:0];
          OFF_SPAN: span_n[c] = wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      en_q     <= '0;
      pre_q    <= '0;
      high_q   <= '0;
      span_q   <= '0;
    end else if (wr_en) begin
      master_q <= master_n;
      en_q     <= en_n;
      pre_q    <= pre_n;
      high_q   <= high_n;
      span_q   <= span_n;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == MASTER_A) rd_data[EN_BIT] = master_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr[ADDR_W-1:WIN_W] == c[SEL_W-1:0]) begin
        case (rd_addr[WIN_W-1:0])
          OFF_CTRL: begin
            rd_data[EN_BIT]             = en_q[c];
            rd_data[PRE_LSB +: PRE_W]   = pre_q[c];
          end
          OFF_HIGH: rd_data[CNT_W-1:0] = high_q[c];
          OFF_SPAN: rd_data[CNT_W-1:0] = span_q[c];
          default: ;
        endcase
      end
    end
  end

  assign master_en = master_q;
  assign ch_en     = en_q;
  assign ch_pre    = pre_q;
  assign ch_high   = high_q;
  assign ch_span   = span_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PRE_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] span_i,
  output logic             wave_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] span_o
);
  logic             run_q;
  logic [PRE_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PRE_W-1:0] wpre_q;
  logic [CNT_W-1:0] whigh_q, wspan_q;
  logic [CNT_W:0]   cnt_inc;
  logic             tick, last, count_en, reload;

  always_comb begin
    count_en = run & run_q;
    tick     = (div_q == wpre_q);
    cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    last     = (cnt_inc >= {1'b0, wspan_q});
    reload   = ~run_q | (count_en & tick & last);
    div_n    = '0;
    cnt_n    = '0;
    if (count_en) begin
      div_n = tick ? '0 : div_q + PRE_W'(1);
      cnt_n = tick ? (last ? '0 : cnt_inc[CNT_W-1:0]) : cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run;
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpre_q  <= '0;
      whigh_q <= '0;
      wspan_q <= '0;
    end else if (reload) begin
      wpre_q  <= pre_i;
      whigh_q <= high_i;
      wspan_q <= span_i;
    end
  end

  assign wave_o = count_en & (wspan_q != '0) & (cnt_q < whigh_q);
  assign cnt_o  = cnt_q;
  assign span_o = wspan_q;
endmodule

// File: rtl/pwm_multi_ctrl.sv
module pwm_multi_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRE_W  = 14,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NUM_CH-1:0] pwm_o
);
  logic                         rst_sync_n;
  logic                         master_en;
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0]            ch_run;
  logic [NUM_CH-1:0][PRE_W-1:0] ch_pre;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_high;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_span;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_wspan;

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_regs #(
    .NUM_CH (NUM_CH),
    .PRE_W  (PRE_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .master_en (master_en),
    .ch_en     (ch_en),
    .ch_pre    (ch_pre),
    .ch_high   (ch_high),
    .ch_span   (ch_span)
  );

  assign ch_run = ch_en & {NUM_CH{master_en}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan #(
      .PRE_W (PRE_W),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .run    (ch_run[g]),
      .pre_i  (ch_pre[g]),
      .high_i (ch_high[g]),
      .span_i (ch_span[g]),
      .wave_o (pwm_o[g]),
      .cnt_o  (ch_cnt[g]),
      .span_o (ch_wspan[g])
    );
  end
endmodule

// File: rtl/pwm_multi_ctrl_chk.sv
module pwm_multi_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic                         wr_bit0,
  input logic                         master_en,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            pwm_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_wspan
);
  // R6
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (pwm_o == '0));

  // R2
  master_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(8'h3C)) |=> (master_en == $past(wr_bit0)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    // R7
    chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |-> !pwm_o[g]);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_cnt[g] != '0) |-> (ch_cnt[g] < ch_wspan[g]));

    // R10
    zero_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wspan[g] == '0) |-> !pwm_o[g]);
  end
endmodule

bind pwm_multi_ctrl pwm_multi_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_bit0   (wr_data[0]),
  .master_en (master_en),
  .ch_en     (ch_en),
  .pwm_o     (pwm_o),
  .ch_cnt    (ch_cnt),
  .ch_wspan  (ch_wspan)
);

// File: tb/sim_pwm_multi_ctrl.sv
`timescale 1ns/100ps
module sim_pwm_multi_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_multi_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .pwm_o (pwm_o)
  );

  // behavioural reference: register image plus elapsed-cycle timer per channel
  logic [31:0] m_ctrl [4];
  logic [31:0] m_high [4];
  logic [31:0] m_span [4];
  logic        m_master;
  bit          m_runq [4];
  int          m_el [4];
  int          m_pre [4];
  int          m_dh [4];
  int          m_sp [4];

  function automatic int plen(int c);
    return (m_pre[c] + 1) * ((m_sp[c] == 0) ? 1 : m_sp[c]);
  endfunction

  function automatic bit m_run(int c);
    return m_master && m_ctrl[c][0];
  endfunction

  function automatic bit m_out(int c);
    return m_run(c) && m_runq[c] && (m_sp[c] != 0) && (m_el[c] < (m_pre[c] + 1) * m_dh[c]);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h3C) return {31'd0, m_master};
    if (a < 8'h40) begin
      case (a[3:0])
        4'h0: return m_ctrl[a[5:4]];
        4'h4: return m_high[a[5:4]];
        4'h8: return m_span[a[5:4]];
        default: return 32'd0;
      endcase
    end
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_master <= 1'b0;
      for (int c = 0; c < 4; c++) begin
        m_ctrl[c] <= '0; m_high[c] <= '0; m_span[c] <= '0;
        m_runq[c] <= 0; m_el[c] <= 0; m_pre[c] <= 0; m_dh[c] <= 0; m_sp[c] <= 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit en;
        bit wrap;
        en   = m_run(c) && m_runq[c];
        wrap = en && (m_el[c] + 1 >= plen(c));
        if (!m_runq[c] || wrap) begin
          m_pre[c] <= int'((m_ctrl[c] >> 2) & 32'h3FFF);
          m_dh[c]  <= int'(m_high[c]);
          m_sp[c]  <= int'(m_span[c]);
        end
        m_el[c]   <= (en && !wrap) ? m_el[c] + 1 : 0;
        m_runq[c] <= m_run(c);
      end
      if (wr_en) begin
        if (wr_addr == 8'h3C) m_master <= wr_data[0];
        else if (wr_addr < 8'h40) begin
          case (wr_addr[3:0])
            4'h0: m_ctrl[wr_addr[5:4]] <= wr_data & 32'h0000_FFFD;
            4'h4: m_high[wr_addr[5:4]] <= wr_data & 32'h0000_FFFF;
            4'h8: m_span[wr_addr[5:4]] <= wr_data & 32'h0000_FFFF;
            default: ;
          endcase
        end
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        n_cmp++;
        if (pwm_o[c] !== m_out(c)) begin
          n_bad++;
          $display("FAIL R5 wave ch%0d t=%0t actual=%0b expected=%0b", c, $time, pwm_o[c], m_out(c));
        end
      end
      n_cmp++;
      if (rd_data !== m_read(rd_addr)) begin
        n_bad++;
        $display("FAIL R2 readback addr=%h actual=%h expected=%h", rd_addr, rd_data, m_read(rd_addr));
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(rd_data === exp, tag, int'(rd_data), int'(exp));
  endtask

  task automatic measure(int c, int ehi, int elo, string tag);
    int hi = 0;
    int lo = 0;
    @(negedge clk);
    while (pwm_o[c]) @(negedge clk);
    while (!pwm_o[c]) @(negedge clk);
    while (pwm_o[c]) begin hi++; @(negedge clk); end
    while (!pwm_o[c]) begin lo++; @(negedge clk); end
    check(hi == ehi, {tag, " high"}, hi, ehi);
    check(lo == elo, {tag, " low"}, lo, elo);
  endtask

  task automatic hold_chk(int c, bit lvl, int cycles, string tag);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_o[c] !== lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(pwm_o == 4'b0, "R1 outputs after reset", int'(pwm_o), 0);
    for (int c = 0; c < 4; c++) begin
      rd_chk(8'(c * 16),     32'd0, "R1 ctrl reset");
      rd_chk(8'(c * 16 + 4), 32'd0, "R1 high reset");
      rd_chk(8'(c * 16 + 8), 32'd0, "R1 span reset");
    end
    rd_chk(8'h3C, 32'd0, "R1 master reset");

    // program four channels, master still off (R4 control layout)
    wr(8'h04, 32'd3);  wr(8'h08, 32'd10); wr(8'h00, (32'd0 << 2) | 32'd1);
    wr(8'h14, 32'd2);  wr(8'h18, 32'd6);  wr(8'h10, (32'd2 << 2) | 32'd1);
    wr(8'h24, 32'd5);  wr(8'h28, 32'd5);  wr(8'h20, (32'd4 << 2) | 32'd1);
    wr(8'h34, 32'd4);  wr(8'h38, 32'd0);  wr(8'h30, (32'd1 << 2) | 32'd1);
    rd_chk(8'h10, 32'h9, "R2 R4 ctrl ch1 readback");
    rd_chk(8'h18, 32'd6, "R2 span ch1 readback");
    rd_chk(8'h24, 32'd5, "R2 high ch2 readback");
    for (int c = 0; c < 4; c++) hold_chk(c, 1'b0, 12, "R6 master off keeps low");

    wr(8'h3C, 32'd1);
    measure(0, 3, 7,   "R5 ch0 P0 N10 D3");
    measure(1, 6, 12,  "R5 R11 ch1 P2 N6 D2");
    hold_chk(2, 1'b1, 60, "R9 high >= period stays high");
    hold_chk(3, 1'b0, 40, "R10 zero period stays low");

    // R8: change high time right after a rising edge of ch0
    begin
      int hi = 1;
      @(negedge clk);
      while (pwm_o[0]) @(negedge clk);
      while (!pwm_o[0]) @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'd8;
      @(negedge clk);
      wr_en = 1'b0;
      while (pwm_o[0]) begin hi++; @(negedge clk); end
      check(hi == 3, "R8 current pulse keeps old high time", hi, 3);
    end
    measure(0, 8, 2, "R8 new high time after boundary");

    // R7: disable ch1, then restart
    wr(8'h10, 32'd2 << 2);
    check(pwm_o[1] == 1'b0, "R7 disabled low next cycle", int'(pwm_o[1]), 0);
    hold_chk(1, 1'b0, 20, "R7 disabled stays low");
    rd_chk(8'h10, 32'h8, "R7 R2 ctrl readback with enable clear");
    begin
      int hi = 0;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h10; wr_data = (32'd2 << 2) | 32'd1;
      @(negedge clk);
      wr_en = 1'b0;
      check(pwm_o[1] == 1'b0, "R7 low one cycle after enable", int'(pwm_o[1]), 0);
      @(negedge clk);
      check(pwm_o[1] == 1'b1, "R7 rises two cycles after enable", int'(pwm_o[1]), 1);
      while (pwm_o[1]) begin hi++; @(negedge clk); end
      check(hi == 6, "R7 full first pulse after restart", hi, 6);
    end

    // R3: reserved bits and unmapped addresses
    wr(8'h38, 32'hFFFF_0000);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h0000_FFFD, "R3 ctrl reserved bits");
    rd_chk(8'h38, 32'h0000_0000, "R3 span upper bits");
    wr(8'h34, 32'hFFFF_FFFF);
    rd_chk(8'h34, 32'h0000_FFFF, "R3 high upper bits");
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk(8'h3C, 32'h1, "R3 master upper bits");
    rd_chk(8'h0C, 32'd0, "R3 unmapped window slot");
    rd_chk(8'h40, 32'd0, "R3 beyond last window");

    // R6: master clear gates every output at once
    wr(8'h3C, 32'd0);
    check(pwm_o == 4'b0, "R6 master clear", int'(pwm_o), 0);
    for (int c = 0; c < 4; c++) hold_chk(c, 1'b0, 10, "R6 master clear holds low");

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule